// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a cycle-accurate model of a synchronous single-port memory with a 64-bit data path. It accepts one command per enabled clock, and a read may follow a write, or a write a read, in the next cycle with no idle slot between them. A read samples its address on one rising edge. Its word is loaded into an output register on the next enabled edge and stays on `dout` until the edge after that. A write samples its address on one edge and takes its data from `din` two enabled edges later. The read data and the write data of one command therefore occupy the same bus slot.

Writes are still pending for two cycles after their command. The core checks them against reads and forwards the pending write data to a read of the same address, merged per 32-bit half according to that write's half enables. Output enable acts without a clock. It gates the data drive-enable, which a pad ring uses to tri-state the bus. The storage depth is set by `ADDR_W`. A full-size part would use 19 address bits, and the default here is small so that simulation stays quick.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0 at an enabled edge. Any other combination is a bubble: it does not access the array, and `dout_en` stays 0 in the slot where its read data would have appeared.
- R2: A read accepted at enabled edge k (`we_n`=1) presents the word on `dout` after edge k+1, held until edge k+2, with `dout_en`=1 while `oe_n`=0.
- R3: A write accepted at edge k (`we_n`=0) takes `din` at enabled edge k+2. `bw_n[0]` (active low) guards bits 31:0 and `bw_n[1]` guards bits 63:32. A half whose bit is 1 keeps its old contents.
- R4: A read accepted one edge after a write to the same address returns that write's `din` in the enabled halves and the stored contents in the others.
- R5: Reads and writes may alternate on every edge with no idle cycle, and every read returns the data of all writes accepted before it.
- R6: A selected read with `oe_n`=1 is a dummy read. `dout_en` stays 0 and the array is not changed, but the output register is still loaded.
- R7: `oe_n` gates `dout_en` combinationally. Lowering it between edges exposes the registered read word without a clock edge.
- R8: When `cke_n`=1 at an edge, every pipeline stage and the output register hold their state. The command on the inputs is ignored, and `din` is not taken for a pending write.
- R9: A synchronous reset (`rst`=1) empties the pipeline, so a pending write never commits and `dout_en` goes to 0. Stored words are kept.
- R10: A selected write with `bw_n`=2'b11 leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Second chip select, active low |
| we_n | input | 1 | 0 = write, 1 = read |
| bw_n | input | 2 | Per-half write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | 64 | Write data, taken two enabled edges after the command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 64 | Registered read word |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The hardest case is a read that lands one edge behind a write to the same address. The write's data is then not yet in the array but is on `din` at the very edge where the read word is registered. The bench issues a write, then a read of the same word on the next edge, and supplies the write data on the edge after that. It does this once with both halves enabled and once with only the upper half, to expose the per-half merge. A second hard case is a stall inserted while a write waits for its data. The bench raises `cke_n` on the edge where a naive pipeline would take `din`, puts junk on `din` during the stall, and checks that the word supplied on the next enabled edge is the one stored.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 5,
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cke_n,
  input  logic                  cs_a_n,
  input  logic                  cs_b,
  input  logic                  cs_c_n,
  input  logic                  we_n,
  input  logic [1:0]            bw_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*HALF_W-1:0]   din,
  input  logic                  oe_n,
  output logic [2*HALF_W-1:0]   dout,
  output logic                  dout_en
);
  localparam int DW    = 2 * HALF_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  logic              s1_v, s1_we, s2_v, s2_we, rd_v;
  logic [1:0]        s1_bw, s2_bw;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [DW-1:0]     q_r, rd_word;

  wire go  = !cke_n;
  wire sel = !cs_a_n && cs_b && !cs_c_n;
  wire fwd = s2_v && s2_we && (s2_a == s1_a);

  always_comb begin
    rd_word = mem[s1_a];
    for (int h = 0; h < 2; h++)
      if (fwd && !s2_bw[h]) rd_word[h*HALF_W +: HALF_W] = din[h*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      rd_v <= 1'b0;
    end else if (go) begin
      s1_v  <= sel;
      s1_we <= !we_n;
      s1_bw <= bw_n;
      s1_a  <= addr;
      s2_v  <= s1_v;
      s2_we <= s1_we;
      s2_bw <= s1_bw;
      s2_a  <= s1_a;
      rd_v  <= s1_v && !s1_we;
      if (s1_v && !s1_we) q_r <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && go && s2_v && s2_we)
      for (int h = 0; h < 2; h++)
        if (!s2_bw[h]) mem[s2_a][h*HALF_W +: HALF_W] <= din[h*HALF_W +: HALF_W];
  end

  assign dout    = q_r;
  assign dout_en = rd_v && !oe_n;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> $stable(s1_v) && $stable(s2_v) && $stable(rd_v) && $stable(q_r));

  // R1
  desel_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    go && !sel |=> !s1_v);

  // R2
  read_fill_chk: assert property (@(posedge clk) disable iff (rst)
    go && s1_v && !s1_we |=> rd_v);

  // R3
  lo_commit_chk: assert property (@(posedge clk) disable iff (rst)
    go && s2_v && s2_we && !s2_bw[0] |=> mem[$past(s2_a)][HALF_W-1:0] == $past(din[HALF_W-1:0]));

  // R4
  fwd_hi_chk: assert property (@(posedge clk) disable iff (rst)
    go && fwd && s1_v && !s1_we && !s2_bw[1] |=> q_r[DW-1:HALF_W] == $past(din[DW-1:HALF_W]));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !s1_v && !s2_v && !rd_v);
endmodule

// File: tb/test_zt_sram.sv
module test_zt_sram;
  localparam int AW = 5;
  localparam logic [2:0] ON  = 3'b010;
  localparam logic [2:0] OFF = 3'b110;

  logic clk = 0, rst = 1, cke_n = 0, cs_a_n = 1, cs_b = 0, cs_c_n = 1, we_n = 1, oe_n = 0;
  logic [1:0] bw_n = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [63:0] din = '0, dout;
  logic dout_en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .HALF_W(32)) i_zt_sram (
    .clk(clk), .rst(rst), .cke_n(cke_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .we_n(we_n), .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en));

  task automatic step(input logic ck, input logic [2:0] s, input logic w,
                      input logic [1:0] b, input logic [AW-1:0] a, input logic [63:0] d);
    cke_n = ck; {cs_a_n, cs_b, cs_c_n} = s; we_n = w; bw_n = b; addr = a; din = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_d(input string r, input logic [63:0] exp);
    n_chk++;
    if (dout !== exp || dout_en !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: dout=%h en=%b expected %h en=1", r, dout, dout_en, exp);
    end
  endtask

  task automatic chk_off(input string r);
    n_chk++;
    if (dout_en !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: dout_en=%b expected 0", r, dout_en);
    end
  endtask

  function automatic logic [63:0] pat(input int k);
    return {32'hA500_0000 + k, 32'h005A_0000 + k * 3};
  endfunction

  task automatic t_reset;
    step(0, OFF, 1, 0, 0, 0);
    chk_off("R9 reset state");
  endtask

  task automatic t_basic;
    step(0, ON, 0, 2'b00, 1, 0);
    step(0, ON, 0, 2'b00, 2, 0);
    step(0, OFF, 1, 0, 0, pat(1));
    step(0, OFF, 1, 0, 0, pat(2));
    step(0, ON, 1, 0, 1, 0);
    step(0, ON, 1, 0, 2, 0);
    chk_d("R2 read addr1", pat(1));
    step(0, OFF, 1, 0, 0, 0);
    chk_d("R3 read addr2", pat(2));
    step(0, OFF, 1, 0, 0, 0);
    chk_off("R1 deselect slot");
  endtask

  task automatic t_halves;
    step(0, ON, 0, 2'b00, 3, 0);
    step(0, OFF, 1, 0, 0, 0);
    step(0, ON, 0, 2'b10, 3, pat(3));
    step(0, ON, 0, 2'b11, 1, 0);
    step(0, OFF, 1, 0, 0, pat(4));
    step(0, OFF, 1, 0, 0, pat(9));
    step(0, ON, 1, 0, 3, 0);
    step(0, ON, 1, 0, 1, 0);
    chk_d("R3 lower half only", {pat(3)[63:32], pat(4)[31:0]});
    step(0, OFF, 1, 0, 0, 0);
    chk_d("R10 abort leaves word", pat(1));
  endtask

  task automatic t_forward;
    step(0, ON, 0, 2'b00, 4, 0);
    step(0, ON, 1, 0, 4, 0);
    step(0, OFF, 1, 0, 0, pat(5));
    chk_d("R4 forward full", pat(5));
    step(0, ON, 0, 2'b01, 4, 0);
    step(0, ON, 1, 0, 4, 0);
    step(0, OFF, 1, 0, 0, pat(6));
    chk_d("R4 forward upper merge", {pat(6)[63:32], pat(5)[31:0]});
    step(0, ON, 0, 2'b00, 5, 0);
    step(0, OFF, 1, 0, 0, 0);
    step(0, ON, 1, 0, 5, pat(7));
    step(0, OFF, 1, 0, 0, 0);
    chk_d("R3 read two after write", pat(7));
  endtask

  task automatic t_turnaround;
    step(0, ON, 1, 0, 1, 0);
    step(0, ON, 0, 2'b00, 6, 0);
    chk_d("R5 read a1", pat(1));
    step(0, ON, 1, 0, 2, 0);
    step(0, ON, 0, 2'b00, 7, pat(8));
    chk_d("R5 read a2", pat(2));
    step(0, ON, 1, 0, 6, 0);
    step(0, OFF, 1, 0, 0, pat(10));
    chk_d("R5 read a6", pat(8));
    step(0, ON, 1, 0, 7, 0);
    step(0, OFF, 1, 0, 0, 0);
    chk_d("R5 read a7", pat(10));
  endtask

  task automatic t_dummy_oe;
    oe_n = 1;
    step(0, ON, 1, 0, 2, 0);
    step(0, OFF, 1, 0, 0, 0);
    chk_off("R6 dummy read hidden");
    oe_n = 0; #1;
    chk_d("R7 async oe low", pat(2));
    oe_n = 1; #1;
    chk_off("R7 async oe high");
    oe_n = 0;
    step(0, OFF, 1, 0, 0, 0);
  endtask

  task automatic t_stall;
    step(0, ON, 1, 0, 2, 0);
    step(1, ON, 1, 0, 1, 0);
    chk_off("R8 stall holds read");
    step(0, OFF, 1, 0, 0, 0);
    chk_d("R8 read after stall", pat(2));
    step(0, OFF, 1, 0, 0, 0);
    chk_off("R8 stalled command ignored");
    step(0, ON, 0, 2'b00, 8, 0);
    step(0, OFF, 1, 0, 0, 0);
    step(1, ON, 0, 2'b00, 9, 64'hDEAD_BEEF_DEAD_BEEF);
    step(0, OFF, 1, 0, 0, pat(11));
    step(0, ON, 1, 0, 8, 0);
    step(0, OFF, 1, 0, 0, 0);
    chk_d("R8 write data after stall", pat(11));
  endtask

  task automatic t_select;
    step(0, 3'b000, 1, 0, 1, 0);
    step(0, OFF, 1, 0, 0, 0);
    chk_off("R1 cs_b low no read");
    step(0, 3'b011, 0, 2'b00, 1, 0);
    step(0, 3'b110, 0, 2'b00, 1, 0);
    step(0, OFF, 1, 0, 0, 64'hBAD0_BAD0_BAD0_BAD0);
    step(0, OFF, 1, 0, 0, 64'hBAD1_BAD1_BAD1_BAD1);
    step(0, ON, 1, 0, 1, 0);
    step(0, OFF, 1, 0, 0, 0);
    chk_d("R1 deselected writes ignored", pat(1));
  endtask

  task automatic t_reset_pending;
    step(0, ON, 0, 2'b00, 2, 0);
    rst = 1;
    step(0, OFF, 1, 0, 0, 0);
    chk_off("R9 reset clears output");
    rst = 0;
    step(0, OFF, 1, 0, 0, 64'hBAD2_BAD2_BAD2_BAD2);
    step(0, ON, 1, 0, 2, 0);
    step(0, OFF, 1, 0, 0, 0);
    chk_d("R9 pending write dropped, array kept", pat(2));
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    t_reset();
    t_basic();
    t_halves();
    t_forward();
    t_turnaround();
    t_dummy_oe();
    t_stall();
    t_select();
    t_reset_pending();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule